// File: doc/BRIEF.md
# Mosaic Black Level Correction Stage

This block removes the sensor dark offset from a raw single-plane mosaic video stream and rescales each sample with a per-channel gain. It takes one pixel per clock, tagged with start-of-frame and end-of-line markers. It picks one of four colour channels from the pixel's row and column parity within a 2x2 tile whose arrangement is programmable. It subtracts that channel's pedestal and multiplies the difference by the channel's unsigned fixed-point gain. The result leaves on an output stream of the same format, two clocks later.

Software programs a control word, a line count, four pedestals and four gains. Each write lands in a shadow copy, and a write to the commit address marks the shadow set as pending. A pending set is loaded into the working copy at the next accepted start-of-frame, so one frame never mixes two coefficient sets. The status word shows whether a frame is in progress and whether a commit is pending. An 8-bit checksum of the most recent completed output frame can be read back.

A frame-tracking state machine has two states. `FR_IDLE` means no frame is in progress, and `FR_ACTIVE` means a frame is being received. Transition `T_START` (FR_IDLE to FR_ACTIVE) happens on an accepted start-of-frame pixel that is not also the end of the frame's final line. Transition `T_END` (FR_ACTIVE to FR_IDLE) happens on the end-of-line pixel of the final line. Transition `T_RESTART` (FR_ACTIVE to FR_ACTIVE) happens on a fresh start-of-frame, which resets the position counters. In all other cases the state holds.

Top module: `cfa_black_level`

## Requirements
- R1: The channel index is {row_parity XOR ctrl[2], col_parity XOR ctrl[1]}. Row and column parity are both 0 at a start-of-frame pixel. Column parity toggles on each pixel and returns to 0 after an end-of-line pixel. Row parity toggles after each end-of-line pixel.
- R2: When the sample is at or above its channel pedestal, the output is round_half_up((sample - pedestal) * gain / 2^18), saturated to DATA_W bits. The gain is an 18-bit unsigned value whose MSB weighs 2^-1.
- R3: With the reflect option built in (REFLECT=1, the default) and ctrl[3]=0, a sample below its pedestal uses the difference pedestal - sample, scaled as in R2.
- R4: When ctrl[3] (clip) is 1, a sample below its pedestal gives 0.
- R5: When ctrl[0] (bypass) is 1, the output sample equals the input sample.
- R6: Writes to the control word (address 0), the line count (1), the pedestals (5 to 8, channels 0 to 3) and the gains (9 to 12) have no effect on the output until a commit has been written and a start-of-frame pixel has been accepted.
- R7: A write of any value to address 2 (commit) sets status bit 1 on the next cycle. The bit clears when an accepted start-of-frame pixel applies the pending set.
- R8: Status bit 0 (address 3) reads 1 after an accepted start-of-frame pixel. It reads 0 after the end-of-line pixel of the line whose index equals the line count minus one.
- R9: Address 4 reads the modulo-256 sum of all output samples of the last completed frame. The value is latched when the final line's end-of-line sample leaves the block.
- R10: Every accepted input pixel appears at the output exactly two clocks later, with its start-of-frame and end-of-line markers.
- R11: After reset, out_valid, the status word and the checksum are all 0.
- R12: Reading an address from 0, 1 or 5 to 12 returns the shadow value last written to it, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_waddr | input | 4 | Register write address |
| cfg_wdata | input | 32 | Register write data |
| cfg_raddr | input | 4 | Register read address |
| cfg_rdata | output | 32 | Register read data (combinational) |
| in_valid | input | 1 | Input pixel valid |
| in_sof | input | 1 | Input start-of-frame marker |
| in_eol | input | 1 | Input end-of-line marker |
| in_data | input | DATA_W | Input raw sample |
| out_valid | output | 1 | Output pixel valid |
| out_sof | output | 1 | Output start-of-frame marker |
| out_eol | output | 1 | Output end-of-line marker |
| out_data | output | DATA_W | Corrected sample |

## Verification
The assertions take it for granted that both markers are only meaningful when valid is high, and that a commit write and a start-of-frame pixel may coincide only when the bench intends it to. They also assume in_valid stays low through reset, so that the two-cycle latency check has a clean history. The stimulus keeps markers low on idle cycles and drives every input on the falling edge. It sends only whole frames whose line count matches the committed value, and it never writes registers while a checked frame is in flight.

// File: rtl/blc_pkg.sv
package blc_pkg;
    localparam int SCL_W = 18;
    localparam int NCH   = 4;
    localparam int ADR_W = 4;

    localparam logic [ADR_W-1:0] A_CTRL   = 4'd0;
    localparam logic [ADR_W-1:0] A_LINES  = 4'd1;
    localparam logic [ADR_W-1:0] A_COMMIT = 4'd2;
    localparam logic [ADR_W-1:0] A_STATUS = 4'd3;
    localparam logic [ADR_W-1:0] A_CHKSUM = 4'd4;
    localparam logic [ADR_W-1:0] A_PED0   = 4'd5;
    localparam logic [ADR_W-1:0] A_SCL0   = 4'd9;

    typedef enum logic [0:0] {
        FR_IDLE   = 1'b0,
        FR_ACTIVE = 1'b1
    } frame_state_t;

    typedef struct packed {
        logic       clip;
        logic [1:0] phase;
        logic       bypass;
    } ctrl_t;
endpackage

// File: rtl/blc_regs.sv
module blc_regs
    import blc_pkg::*;
#(
    parameter int DATA_W    = 12,
    parameter int LINE_W    = 16,
    parameter int DEF_LINES = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we,
    input  logic [ADR_W-1:0]                waddr,
    input  logic [31:0]                     wdata,
    input  logic [ADR_W-1:0]                raddr,
    output logic [31:0]                     rdata,
    input  logic                            frame_start,
    input  logic                            running,
    input  logic [7:0]                      checksum,
    output logic                            pending,
    output ctrl_t                           act_ctrl,
    output logic [NCH-1:0][DATA_W-1:0]      act_ped,
    output logic [NCH-1:0][SCL_W-1:0]       act_scl,
    output ctrl_t                           eff_ctrl,
    output logic [LINE_W-1:0]               eff_lines,
    output logic [NCH-1:0][DATA_W-1:0]      eff_ped,
    output logic [NCH-1:0][SCL_W-1:0]       eff_scl
);
    ctrl_t                       sh_ctrl;
    logic [LINE_W-1:0]           sh_lines, act_lines;
    logic [NCH-1:0][DATA_W-1:0]  sh_ped;
    logic [NCH-1:0][SCL_W-1:0]   sh_scl;
    logic                        commit_wr, apply;

    assign commit_wr = we && (waddr == A_COMMIT);
    assign apply     = frame_start && pending;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_ctrl  <= '0;
            sh_lines <= LINE_W'(DEF_LINES);
            sh_ped   <= '0;
            sh_scl   <= '0;
        end else if (we) begin
            if (waddr == A_CTRL)  sh_ctrl  <= ctrl_t'(wdata[3:0]);
            if (waddr == A_LINES) sh_lines <= wdata[LINE_W-1:0];
            for (int k = 0; k < NCH; k++) begin
                if (waddr == A_PED0 + ADR_W'(k)) sh_ped[k] <= wdata[DATA_W-1:0];
                if (waddr == A_SCL0 + ADR_W'(k)) sh_scl[k] <= wdata[SCL_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending   <= 1'b0;
            act_ctrl  <= '0;
            act_lines <= LINE_W'(DEF_LINES);
            act_ped   <= '0;
            act_scl   <= '0;
        end else begin
            pending <= commit_wr || (pending && !frame_start);
            if (apply) begin
                act_ctrl  <= sh_ctrl;
                act_lines <= sh_lines;
                act_ped   <= sh_ped;
                act_scl   <= sh_scl;
            end
        end
    end

    always_comb begin
        eff_ctrl  = apply ? sh_ctrl  : act_ctrl;
        eff_lines = apply ? sh_lines : act_lines;
        eff_ped   = apply ? sh_ped   : act_ped;
        eff_scl   = apply ? sh_scl   : act_scl;
    end

    always_comb begin
        rdata = '0;
        case (raddr)
            A_CTRL:   rdata = {28'd0, sh_ctrl};
            A_LINES:  rdata = 32'(sh_lines);
            A_STATUS: rdata = {30'd0, pending, running};
            A_CHKSUM: rdata = {24'd0, checksum};
            default: begin
                for (int k = 0; k < NCH; k++) begin
                    if (raddr == A_PED0 + ADR_W'(k)) rdata = 32'(sh_ped[k]);
                    if (raddr == A_SCL0 + ADR_W'(k)) rdata = 32'(sh_scl[k]);
                end
            end
        endcase
    end
endmodule

// File: rtl/blc_frame_fsm.sv
module blc_frame_fsm
    import blc_pkg::*;
#(
    parameter int LINE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eol,
    input  logic [LINE_W-1:0] lines,
    input  logic [1:0]        phase,
    output logic [1:0]        chan,
    output logic              last,
    output logic              running
);
    frame_state_t      state, state_d;
    logic              col_q, row_q, cur_col, cur_row, is_last, sof_take, end_take;
    logic [LINE_W-1:0] line_q, cur_line;

    assign cur_col  = in_sof ? 1'b0 : col_q;
    assign cur_row  = in_sof ? 1'b0 : row_q;
    assign cur_line = in_sof ? '0 : line_q;
    assign is_last  = (cur_line == lines - LINE_W'(1));
    assign sof_take = in_valid && in_sof;
    assign end_take = in_valid && in_eol && is_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= FR_IDLE;
            col_q  <= 1'b0;
            row_q  <= 1'b0;
            line_q <= '0;
        end else begin
            state <= state_d;
            if (in_valid) begin
                col_q  <= in_eol ? 1'b0 : !cur_col;
                row_q  <= in_eol ? !cur_row : cur_row;
                line_q <= in_eol ? cur_line + LINE_W'(1) : cur_line;
            end
        end
    end

    always_comb begin
        state_d = state;
        unique case (state)
            FR_IDLE:   if (sof_take && !end_take) state_d = FR_ACTIVE;
            FR_ACTIVE: if (end_take)              state_d = FR_IDLE;
            default:                              state_d = FR_IDLE;
        endcase
    end

    always_comb begin
        running = (state == FR_ACTIVE);
        chan    = {cur_row ^ phase[1], cur_col ^ phase[0]};
        last    = in_eol && is_last;
    end
endmodule

// File: rtl/blc_datapath.sv
module blc_datapath
    import blc_pkg::*;
#(
    parameter int DATA_W  = 12,
    parameter bit REFLECT = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic                        in_sof,
    input  logic                        in_eol,
    input  logic                        in_last,
    input  logic [DATA_W-1:0]           in_data,
    input  logic [1:0]                  chan,
    input  ctrl_t                       ctrl,
    input  logic [NCH-1:0][DATA_W-1:0]  ped,
    input  logic [NCH-1:0][SCL_W-1:0]   scl,
    output logic                        out_valid,
    output logic                        out_sof,
    output logic                        out_eol,
    output logic                        out_last,
    output logic [DATA_W-1:0]           out_data
);
    localparam int PROD_W = DATA_W + SCL_W + 1;
    localparam logic [PROD_W-1:0] RND = PROD_W'(1) << (SCL_W - 1);
    localparam logic [DATA_W:0]   MAXV = {1'b0, {DATA_W{1'b1}}};

    logic [DATA_W-1:0] sel_ped, diff_d, below_d;
    logic [SCL_W-1:0]  sel_scl;
    logic              s1_v, s1_sof, s1_eol, s1_last, s1_byp;
    logic [DATA_W-1:0] s1_raw, s1_diff;
    logic [SCL_W-1:0]  s1_scl;
    logic [PROD_W-1:0] prod;
    logic [DATA_W:0]   scaled;
    logic [DATA_W-1:0] res;

    assign sel_ped = ped[chan];
    assign sel_scl = scl[chan];

    generate
        if (REFLECT) begin : g_reflect
            assign below_d = ctrl.clip ? '0 : sel_ped - in_data;
        end else begin : g_floor
            assign below_d = '0;
        end
    endgenerate

    assign diff_d = (in_data >= sel_ped) ? in_data - sel_ped : below_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_v <= 1'b0; s1_sof <= 1'b0; s1_eol <= 1'b0; s1_last <= 1'b0;
            s1_byp <= 1'b0; s1_raw <= '0; s1_diff <= '0; s1_scl <= '0;
        end else begin
            s1_v    <= in_valid;
            s1_sof  <= in_valid && in_sof;
            s1_eol  <= in_valid && in_eol;
            s1_last <= in_valid && in_last;
            s1_byp  <= ctrl.bypass;
            s1_raw  <= in_data;
            s1_diff <= diff_d;
            s1_scl  <= sel_scl;
        end
    end

    always_comb begin
        prod   = PROD_W'(s1_diff) * PROD_W'(s1_scl) + RND;
        scaled = prod[SCL_W +: DATA_W+1];
        res    = (scaled > MAXV) ? MAXV[DATA_W-1:0] : scaled[DATA_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0; out_sof <= 1'b0; out_eol <= 1'b0;
            out_last <= 1'b0; out_data <= '0;
        end else begin
            out_valid <= s1_v;
            out_sof   <= s1_sof;
            out_eol   <= s1_eol;
            out_last  <= s1_last;
            out_data  <= s1_byp ? s1_raw : res;
        end
    end
endmodule

// File: rtl/cfa_black_level.sv
module cfa_black_level
    import blc_pkg::*;
#(
    parameter int DATA_W    = 12,
    parameter int LINE_W    = 16,
    parameter int DEF_LINES = 4,
    parameter bit REFLECT   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_waddr,
    input  logic [31:0]       cfg_wdata,
    input  logic [3:0]        cfg_raddr,
    output logic [31:0]       cfg_rdata,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eol,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic              out_sof,
    output logic              out_eol,
    output logic [DATA_W-1:0] out_data
);
    ctrl_t                       act_ctrl, eff_ctrl;
    logic [NCH-1:0][DATA_W-1:0]  act_ped, eff_ped;
    logic [NCH-1:0][SCL_W-1:0]   act_scl, eff_scl;
    logic [LINE_W-1:0]           eff_lines;
    logic                        pending, running, px_last, out_last;
    logic [1:0]                  chan;
    logic [7:0]                  acc_q, chk_q, sum;

    blc_regs #(.DATA_W(DATA_W), .LINE_W(LINE_W), .DEF_LINES(DEF_LINES)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_waddr), .wdata(cfg_wdata),
        .raddr(cfg_raddr), .rdata(cfg_rdata), .frame_start(in_valid && in_sof),
        .running(running), .checksum(chk_q), .pending(pending),
        .act_ctrl(act_ctrl), .act_ped(act_ped), .act_scl(act_scl),
        .eff_ctrl(eff_ctrl), .eff_lines(eff_lines), .eff_ped(eff_ped), .eff_scl(eff_scl)
    );

    blc_frame_fsm #(.LINE_W(LINE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eol(in_eol),
        .lines(eff_lines), .phase(eff_ctrl.phase), .chan(chan), .last(px_last),
        .running(running)
    );

    blc_datapath #(.DATA_W(DATA_W), .REFLECT(REFLECT)) u_dp (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eol(in_eol),
        .in_last(px_last), .in_data(in_data), .chan(chan), .ctrl(eff_ctrl),
        .ped(eff_ped), .scl(eff_scl), .out_valid(out_valid), .out_sof(out_sof),
        .out_eol(out_eol), .out_last(out_last), .out_data(out_data)
    );

    assign sum = (out_sof ? 8'd0 : acc_q) + out_data[7:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            chk_q <= '0;
        end else if (out_valid) begin
            acc_q <= sum;
            if (out_last) chk_q <= sum;
        end
    end
endmodule

// File: rtl/cfa_black_level_chk.sv
module cfa_black_level_chk
    import blc_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [3:0]                  cfg_waddr,
    input  logic                        in_valid,
    input  logic                        in_sof,
    input  logic                        in_eol,
    input  logic                        out_valid,
    input  logic                        out_sof,
    input  logic                        out_eol,
    input  logic                        pending,
    input  logic                        running,
    input  logic [3:0]                  act_ctrl,
    input  logic [NCH-1:0][DATA_W-1:0]  act_ped,
    input  logic [NCH-1:0][SCL_W-1:0]   act_scl
);
    logic [1:0] cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cyc <= '0;
        else if (cyc != 2'd3)  cyc <= cyc + 2'd1;
    end

    // R10: two-cycle latency with aligned markers
    a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3) |-> (out_valid == $past(in_valid, 2)) &&
                          (out_sof == $past(in_valid && in_sof, 2)) &&
                          (out_eol == $past(in_valid && in_eol, 2)));

    a_r10_sof_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid);

    // R7: commit raises pending, start-of-frame consumes it
    a_r7_commit_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_waddr == A_COMMIT) |=> pending);

    a_r7_sof_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && in_valid && in_sof && !(cfg_we && cfg_waddr == A_COMMIT)) |=> !pending);

    // R6: working coefficients move only at a start-of-frame
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((cyc != 2'd0) && !(in_valid && in_sof)) |=>
            ($stable(act_ctrl) && $stable(act_ped) && $stable(act_scl)));

    // R8: a frame that does not end on its first pixel is running
    a_r8_running: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof && !in_eol) |=> running);
endmodule

bind cfa_black_level cfa_black_level_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_waddr(cfg_waddr),
    .in_valid(in_valid), .in_sof(in_sof), .in_eol(in_eol),
    .out_valid(out_valid), .out_sof(out_sof), .out_eol(out_eol),
    .pending(pending), .running(running), .act_ctrl(act_ctrl),
    .act_ped(act_ped), .act_scl(act_scl)
);

// File: tb/cfa_black_level_test.sv
module cfa_black_level_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [3:0]    cfg_waddr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [3:0]    cfg_raddr = 4'd3;
    logic [31:0]   cfg_rdata;
    logic          in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          out_valid, out_sof, out_eol;
    logic [DW-1:0] out_data;

    int total = 0;
    int bad = 0;
    int cap_n = 0;
    logic [DW-1:0] cap_d [16];
    logic          cap_s [16];
    logic          cap_e [16];

    // ped(12) gain(18) sample(12) ctrl(4) expected(12)
    localparam logic [57:0] VEC [8] = '{
        {12'd64,  18'h20000, 12'd264,  4'h0, 12'd100},
        {12'd64,  18'h3FFFF, 12'd4095, 4'h0, 12'd4031},
        {12'd100, 18'h20000, 12'd40,   4'h0, 12'd30},
        {12'd100, 18'h20000, 12'd40,   4'h8, 12'd0},
        {12'd100, 18'h20000, 12'd40,   4'h1, 12'd40},
        {12'd0,   18'h10000, 12'd6,    4'h0, 12'd2},
        {12'd0,   18'h10000, 12'd5,    4'h0, 12'd1},
        {12'd10,  18'h20000, 12'd10,   4'h0, 12'd0}
    };
    localparam logic [11:0] PH_OUT [4] = '{12'd80, 12'd40, 12'd20, 12'd10};

    cfa_black_level uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_waddr(cfg_waddr),
        .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
        .in_valid(in_valid), .in_sof(in_sof), .in_eol(in_eol), .in_data(in_data),
        .out_valid(out_valid), .out_sof(out_sof), .out_eol(out_eol), .out_data(out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (out_valid && cap_n < 16) begin
            cap_d[cap_n] = out_data;
            cap_s[cap_n] = out_sof;
            cap_e[cap_n] = out_eol;
            cap_n = cap_n + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_waddr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        cfg_raddr = a;
        #1;
        d = cfg_rdata;
        cfg_raddr = 4'd3;
    endtask

    // 2x2 frame of one value; checks running during the frame
    task automatic frame(input logic [DW-1:0] v);
        cap_n = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (i > 0) check("R8 running in frame", 32'(cfg_rdata[0]), 32'd1);
            in_valid = 1'b1; in_sof = (i == 0); in_eol = (i % 2 == 1); in_data = v;
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 idle after frame", 32'(cfg_rdata[0]), 32'd0);
        check("R10 frame sample count", 32'(cap_n), 32'd4);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 out_valid", 32'(out_valid), 32'd0);
        rd(4'd3, r); check("R11 status", r, 32'd0);
        rd(4'd4, r); check("R11 checksum", r, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: one-pixel frames on channel 0 (R2 R3 R4 R5 R10)
        wr(4'd1, 32'd1);
        for (int v = 0; v < 8; v++) begin
            wr(4'd5, 32'(VEC[v][57:46]));
            wr(4'd9, 32'(VEC[v][45:28]));
            wr(4'd0, 32'(VEC[v][15:12]));
            wr(4'd2, 32'd0);
            @(negedge clk);
            in_valid = 1'b1; in_sof = 1'b1; in_eol = 1'b1; in_data = VEC[v][27:16];
            @(negedge clk);
            in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
            check("R10 not early", 32'(out_valid), 32'd0);
            @(negedge clk);
            check("R10 valid at two clocks", 32'(out_valid), 32'd1);
            check("R10 markers", 32'({out_sof, out_eol}), 32'd3);
            check($sformatf("R2/R3/R4/R5 vector %0d", v), 32'(out_data), 32'(VEC[v][11:0]));
        end

        // R12 readback of shadow registers
        rd(4'd5, r); check("R12 ped0 readback", r, 32'd10);
        rd(4'd9, r); check("R12 gain0 readback", r, 32'h20000);

        // R1 phase table with distinct gains, zero pedestals
        wr(4'd1, 32'd2);
        wr(4'd5, 32'd0);
        wr(4'd9, 32'h20000); wr(4'd10, 32'h10000); wr(4'd11, 32'h08000); wr(4'd12, 32'h04000);
        for (int p = 0; p < 4; p++) begin
            wr(4'd0, 32'(p << 1));
            wr(4'd2, 32'd0);
            frame(12'd160);
            for (int i = 0; i < 4; i++) begin
                int ch;
                ch = (((i / 2) ^ (p >> 1)) << 1) | ((i % 2) ^ (p & 1));
                check($sformatf("R1 phase %0d pixel %0d", p, i), 32'(cap_d[i]), 32'(PH_OUT[ch]));
            end
            check("R10 sof marker", 32'(cap_s[0]), 32'd1);
            check("R10 eol marker", 32'(cap_e[1]), 32'd1);
        end
        // R9 checksum of last frame (phase 3: 10+20+40+80)
        rd(4'd4, r); check("R9 checksum", r, 32'd150);

        // R6 staging: gain change without commit has no effect
        wr(4'd0, 32'd0); wr(4'd2, 32'd0);
        frame(12'd160);
        wr(4'd9, 32'h08000);
        frame(12'd160);
        check("R6 uncommitted gain ignored", 32'(cap_d[0]), 32'd80);
        rd(4'd9, r); check("R12 shadow gain", r, 32'h08000);
        rd(4'd3, r); check("R7 no pending", r, 32'd0);
        wr(4'd2, 32'd7);
        rd(4'd3, r); check("R7 pending set", r, 32'd2);
        frame(12'd160);
        rd(4'd3, r); check("R7 pending cleared", r, 32'd0);
        check("R6 committed gain", 32'(cap_d[0]), 32'd20);
        rd(4'd4, r); check("R9 checksum staged", r, 32'd90);

        // R5/R9 bypass and modulo-256 checksum
        wr(4'd0, 32'd1); wr(4'd2, 32'd0);
        frame(12'd200);
        check("R5 bypass frame", 32'(cap_d[3]), 32'd200);
        rd(4'd4, r); check("R9 checksum wraps", r, 32'd32);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule